// File: doc/BRIEF.md
# Duplex Processor Recovery Supervisor

This block supervises a pair of processors in which only one runs and the other waits unpowered as a cold spare. It receives two kinds of error evidence. One is a parity-failure strobe raised on memory reads. The other comes from an internal watchdog that the running processor must refresh periodically. For each piece of evidence, the block picks one of three responses. It can stretch the faulty bus access into a short retry window. It can hold the processor while its state is rolled back to the last saved checkpoint. Or it can hand execution over to the spare, which also involves a checkpoint restore and takes the longest of the three.

Escalation is driven by a counter of detections that are not separated by a calm period. When the count reaches a programmable limit, the switchover is taken instead of the normal action. Once the spare is active there is no further backup. A second time the limit is reached, the block therefore enters a permanent safe-stop that only reset clears. A programmable run of error-free cycles wipes the counter, so rare, isolated upsets never add up to a switchover. The watchdog reload value, the detection limit and the length of the calm window are input ports. The lengths of the three recovery windows are parameters.

Top module: `dup_recovery_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, backoff, ckptRestore, mainHold, goSpare, spareEnable and failStop are all low.
- R2: A parity error sampled at a clock edge while no recovery is in progress drives backoff high for exactly BOFF_CYC (default 2) cycles, starting right after that edge. mainHold and ckptRestore stay low during this window.
- R3: The watchdog is reloaded with wdReload by a wdKick sampled in normal running and by every recovery action. If no further kick arrives, it counts down once per running cycle. A rollback starts on the (wdReload+1)-th edge after the last reload. Kicking at least every wdReload cycles prevents any rollback.
- R4: Watchdog expiry drives ckptRestore and mainHold high together for exactly ROLL_CYC (default 4) cycles, and backoff stays low.
- R5: If a parity error and watchdog expiry fall on the same edge, a rollback is started and no retry window is opened.
- R6: When a detection makes the consecutive-detection count reach detectLimit and the spare is unused, a switchover starts. spareEnable rises and then stays high until reset. goSpare, ckptRestore and mainHold are high for exactly SWAP_CYC (default 8) cycles, and the count restarts from zero.
- R7: quietLimit consecutive error-free running cycles clear the detection count. Detections separated by such gaps therefore never reach the limit.
- R8: When the limit is reached again after a switchover, failStop and mainHold go high and stay high until reset, spareEnable stays high, and later errors start no retry.
- R9: Parity errors arriving while a retry, rollback or switchover is in progress are ignored. They open no window and do not add to the detection count.
- R10: A detectLimit of 0 behaves as a limit of 1, so the first detection starts the switchover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| parityErr | input | 1 | Parity failure strobe from the memory read path |
| wdKick | input | 1 | Watchdog refresh from the running processor |
| wdReload | input | WD_W | Watchdog reload value |
| detectLimit | input | CNT_W | Consecutive detections that trigger escalation |
| quietLimit | input | QUIET_W | Error-free running cycles that clear the detection count |
| backoff | output | 1 | Retry window for the faulting bus access |
| ckptRestore | output | 1 | Request to restore the last checkpoint |
| mainHold | output | 1 | Holds the running processor |
| goSpare | output | 1 | High while the switchover to the spare is in progress |
| spareEnable | output | 1 | Powers and enables the spare processor (sticky) |
| failStop | output | 1 | Permanent safe-stop after the spare has also failed |

## Verification
The checker monitors every cycle for the following properties. Each retry window must open only after a sampled parity error. A restore must always come with a processor hold. The retry and restore windows must never overlap. spareEnable and failStop must never fall once set, and goSpare must never appear without spareEnable.

Some behaviours can only be shown by the bench's scenarios. These are the exact window lengths, the point at which the watchdog expires, the point at which the count reaches the limit, the clearing of the count by a calm window, and the fact that errors during a recovery window are not counted. Each of these depends on a history of inputs that the bench sets up deliberately.

// File: rtl/dup_recovery_pkg.sv
package dup_recovery_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_RETRY,
    ST_ROLL,
    ST_SWAP,
    ST_HALT
  } recState_t;

  typedef enum logic [1:0] {
    PH_RETRY,
    PH_ROLL,
    PH_SWAP
  } phaseSel_t;

  // Strobes from the control FSM to the counting datapath
  typedef struct packed {
    logic      wdLoad;
    logic      wdRun;
    logic      detInc;
    logic      detClr;
    logic      quietClr;
    logic      quietRun;
    logic      phaseLoad;
    phaseSel_t phaseSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/dup_recovery_dp.sv
module dup_recovery_dp
  import dup_recovery_pkg::*;
#(
  parameter int WD_W     = 8,
  parameter int CNT_W    = 4,
  parameter int QUIET_W  = 8,
  parameter int BOFF_CYC = 2,
  parameter int ROLL_CYC = 4,
  parameter int SWAP_CYC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [WD_W-1:0]    wdReload,
  input  logic [CNT_W-1:0]   detectLimit,
  input  logic [QUIET_W-1:0] quietLimit,
  output logic               wdExpire,
  output logic               limitHit,
  output logic               quietDone,
  output logic               phaseDone
);

  localparam int MAX_A    = (BOFF_CYC > ROLL_CYC) ? BOFF_CYC : ROLL_CYC;
  localparam int MAX_PH   = (MAX_A > SWAP_CYC) ? MAX_A : SWAP_CYC;
  localparam int PH_W     = $clog2(MAX_PH + 1);
  localparam logic [PH_W-1:0] BOFF_LD = PH_W'(BOFF_CYC - 1);
  localparam logic [PH_W-1:0] ROLL_LD = PH_W'(ROLL_CYC - 1);
  localparam logic [PH_W-1:0] SWAP_LD = PH_W'(SWAP_CYC - 1);

  logic [WD_W-1:0]    wdCount;
  logic [CNT_W-1:0]   detCount;
  logic [QUIET_W-1:0] quietCnt;
  logic [PH_W-1:0]    phaseCnt;
  logic [PH_W-1:0]    phaseLd;
  logic [CNT_W-1:0]   effLimit;

  // Watchdog down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          wdCount <= '1;
    else if (strb.wdLoad)               wdCount <= wdReload;
    else if (strb.wdRun && wdCount != '0) wdCount <= wdCount - 1'b1;
  end
  assign wdExpire = (wdCount == '0);

  // Consecutive detection counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             detCount <= '0;
    else if (strb.detClr)                  detCount <= '0;
    else if (strb.detInc && detCount != '1) detCount <= detCount + 1'b1;
  end
  assign effLimit = (detectLimit == '0) ? CNT_W'(1) : detectLimit;
  assign limitHit = ({1'b0, detCount} + 1'b1) >= {1'b0, effLimit};

  // Error-free window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              quietCnt <= '0;
    else if (strb.quietClr)                 quietCnt <= '0;
    else if (strb.quietRun && !quietDone)   quietCnt <= quietCnt + 1'b1;
  end
  assign quietDone = (quietCnt >= quietLimit);

  // Recovery window length selection
  always_comb begin
    unique case (strb.phaseSel)
      PH_ROLL: phaseLd = ROLL_LD;
      PH_SWAP: phaseLd = SWAP_LD;
      default: phaseLd = BOFF_LD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (strb.phaseLoad)   phaseCnt <= phaseLd;
    else if (phaseCnt != '0)   phaseCnt <= phaseCnt - 1'b1;
  end
  assign phaseDone = (phaseCnt == '0);

endmodule

// File: rtl/dup_recovery_fsm.sv
module dup_recovery_fsm
  import dup_recovery_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        parityErr,
  input  logic        wdKick,
  input  logic        wdExpire,
  input  logic        limitHit,
  input  logic        quietDone,
  input  logic        phaseDone,
  output ctrlStrobe_t strb,
  output logic        backoff,
  output logic        ckptRestore,
  output logic        mainHold,
  output logic        goSpare,
  output logic        spareEnable,
  output logic        failStop
);

  recState_t state, nextState;
  logic      onSpare, nextOnSpare;
  logic      evt;

  assign evt = parityErr || wdExpire;

  always_comb begin
    strb        = '0;
    nextState   = state;
    nextOnSpare = onSpare;
    unique case (state)
      ST_RUN: begin
        strb.wdRun    = 1'b1;
        strb.quietRun = 1'b1;
        strb.wdLoad   = wdKick;
        if (evt) begin
          strb.wdLoad    = 1'b1;
          strb.quietClr  = 1'b1;
          strb.phaseLoad = 1'b1;
          if (limitHit) begin
            strb.detClr = 1'b1;
            if (onSpare) begin
              nextState = ST_HALT;
            end else begin
              nextState     = ST_SWAP;
              strb.phaseSel = PH_SWAP;
              nextOnSpare   = 1'b1;
            end
          end else begin
            strb.detInc = 1'b1;
            // rollback outranks retry on a shared edge
            if (wdExpire) begin
              nextState     = ST_ROLL;
              strb.phaseSel = PH_ROLL;
            end else begin
              nextState     = ST_RETRY;
              strb.phaseSel = PH_RETRY;
            end
          end
        end else if (quietDone) begin
          strb.detClr = 1'b1;
        end
      end
      ST_RETRY, ST_ROLL, ST_SWAP: begin
        strb.wdLoad   = 1'b1;
        strb.quietClr = 1'b1;
        if (phaseDone) nextState = ST_RUN;
      end
      default: begin
        strb.wdLoad   = 1'b1;
        strb.quietClr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      onSpare <= 1'b0;
    end else begin
      state   <= nextState;
      onSpare <= nextOnSpare;
    end
  end

  assign backoff     = (state == ST_RETRY);
  assign ckptRestore = (state == ST_ROLL) || (state == ST_SWAP);
  assign mainHold    = (state == ST_ROLL) || (state == ST_SWAP) || (state == ST_HALT);
  assign goSpare     = (state == ST_SWAP);
  assign spareEnable = onSpare;
  assign failStop    = (state == ST_HALT);

endmodule

// File: rtl/dup_recovery_ctrl.sv
module dup_recovery_ctrl
  import dup_recovery_pkg::*;
#(
  parameter int WD_W     = 8,
  parameter int CNT_W    = 4,
  parameter int QUIET_W  = 8,
  parameter int BOFF_CYC = 2,
  parameter int ROLL_CYC = 4,
  parameter int SWAP_CYC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               parityErr,
  input  logic               wdKick,
  input  logic [WD_W-1:0]    wdReload,
  input  logic [CNT_W-1:0]   detectLimit,
  input  logic [QUIET_W-1:0] quietLimit,
  output logic               backoff,
  output logic               ckptRestore,
  output logic               mainHold,
  output logic               goSpare,
  output logic               spareEnable,
  output logic               failStop
);

  ctrlStrobe_t strb;
  logic wdExpire, limitHit, quietDone, phaseDone;

  dup_recovery_fsm fsm_i (
    .clk(clk), .rstN(rstN), .parityErr(parityErr), .wdKick(wdKick),
    .wdExpire(wdExpire), .limitHit(limitHit), .quietDone(quietDone),
    .phaseDone(phaseDone), .strb(strb), .backoff(backoff),
    .ckptRestore(ckptRestore), .mainHold(mainHold), .goSpare(goSpare),
    .spareEnable(spareEnable), .failStop(failStop)
  );

  dup_recovery_dp #(
    .WD_W(WD_W), .CNT_W(CNT_W), .QUIET_W(QUIET_W),
    .BOFF_CYC(BOFF_CYC), .ROLL_CYC(ROLL_CYC), .SWAP_CYC(SWAP_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wdReload(wdReload),
    .detectLimit(detectLimit), .quietLimit(quietLimit),
    .wdExpire(wdExpire), .limitHit(limitHit), .quietDone(quietDone),
    .phaseDone(phaseDone)
  );

endmodule

// File: rtl/dup_recovery_chk.sv
module dup_recovery_chk (
  input logic clk,
  input logic rstN,
  input logic parityErr,
  input logic backoff,
  input logic ckptRestore,
  input logic mainHold,
  input logic goSpare,
  input logic spareEnable,
  input logic failStop
);

  a_r2_retry_needs_parity: assert property (@(posedge clk) disable iff (!rstN)
    $rose(backoff) |-> $past(parityErr));

  a_r4_restore_holds_cpu: assert property (@(posedge clk) disable iff (!rstN)
    ckptRestore |-> mainHold);

  a_r5_no_retry_with_restore: assert property (@(posedge clk) disable iff (!rstN)
    ckptRestore |-> !backoff);

  a_r6_spare_sticky: assert property (@(posedge clk) disable iff (!rstN)
    spareEnable |=> spareEnable);

  a_r6_swap_enables_spare: assert property (@(posedge clk) disable iff (!rstN)
    goSpare |-> spareEnable);

  a_r8_stop_sticky: assert property (@(posedge clk) disable iff (!rstN)
    failStop |=> (failStop && mainHold));

endmodule

bind dup_recovery_ctrl dup_recovery_chk chk_i (
  .clk(clk), .rstN(rstN), .parityErr(parityErr), .backoff(backoff),
  .ckptRestore(ckptRestore), .mainHold(mainHold), .goSpare(goSpare),
  .spareEnable(spareEnable), .failStop(failStop)
);

// File: tb/dup_recovery_ctrl_tb_top.sv
module dup_recovery_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       parityErr = 1'b0;
  logic       wdKick = 1'b0;
  logic [7:0] wdReload = 8'd3;
  logic [3:0] detectLimit = 4'd15;
  logic [7:0] quietLimit = 8'd200;
  logic backoff, ckptRestore, mainHold, goSpare, spareEnable, failStop;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dup_recovery_ctrl dut_i (
    .clk(clk), .rstN(rstN), .parityErr(parityErr), .wdKick(wdKick),
    .wdReload(wdReload), .detectLimit(detectLimit), .quietLimit(quietLimit),
    .backoff(backoff), .ckptRestore(ckptRestore), .mainHold(mainHold),
    .goSpare(goSpare), .spareEnable(spareEnable), .failStop(failStop)
  );

  // Row: {parityErr, wdKick, expBackoff, expCkptRestore, expMainHold}
  // Reload 3, limit 15, quiet window 200: covers R2, R3, R4, R5, R9.
  localparam logic [4:0] VEC [26] = '{
    5'b01000, 5'b10100, 5'b00100, 5'b00000, 5'b00000, 5'b00000, 5'b00000,
    5'b00011, 5'b10011, 5'b00011, 5'b00011, 5'b00000, 5'b00000, 5'b00000,
    5'b00000, 5'b10011, 5'b00011, 5'b00011, 5'b00011, 5'b00000, 5'b01000,
    5'b01000, 5'b01000, 5'b01000, 5'b01000, 5'b01000
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    parityErr = 1'b0;
    wdKick = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // one parity detection followed by the retry window and return to run
  task automatic parityHit();
    parityErr = 1'b1;
    step();
    parityErr = 1'b0;
    repeat (2) step();
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    doReset();
    chk("R1 backoff", int'(backoff), 0);
    chk("R1 hold", int'(mainHold), 0);
    chk("R1 restore", int'(ckptRestore), 0);
    chk("R1 spare", int'(spareEnable), 0);
    chk("R1 stop", int'(failStop), 0);
    step();
    chk("R1 first cycle goSpare", int'(goSpare), 0);

    // Vector table: R2 retry, R3/R4 expiry, R9 ignored error, R5 priority
    doReset();
    wdReload = 8'd3;
    detectLimit = 4'd15;
    quietLimit = 8'd200;
    foreach (VEC[i]) begin
      parityErr = VEC[i][4];
      wdKick = VEC[i][3];
      step();
      chk($sformatf("R2 backoff row %0d", i), int'(backoff), int'(VEC[i][2]));
      chk($sformatf("R4 restore row %0d", i), int'(ckptRestore), int'(VEC[i][1]));
      chk($sformatf("R5 hold row %0d", i), int'(mainHold), int'(VEC[i][0]));
    end
    parityErr = 1'b0;
    wdKick = 1'b0;

    // R6: third detection switches to the spare
    doReset();
    wdReload = 8'd50;
    detectLimit = 4'd3;
    quietLimit = 8'd200;
    parityHit();
    parityHit();
    parityErr = 1'b1;
    step();
    parityErr = 1'b0;
    chk("R6 goSpare", int'(goSpare), 1);
    chk("R6 spareEnable", int'(spareEnable), 1);
    chk("R6 restore", int'(ckptRestore), 1);
    chk("R6 hold", int'(mainHold), 1);
    chk("R6 no retry", int'(backoff), 0);
    n = 1;
    for (int k = 0; k < 20; k++) begin
      step();
      if (goSpare) n++;
    end
    chk("R6 swap length", n, 8);
    chk("R6 spare stays", int'(spareEnable), 1);
    chk("R6 hold released", int'(mainHold), 0);

    // R8: limit reached again after switchover
    parityHit();
    parityHit();
    chk("R8 not yet stopped", int'(failStop), 0);
    parityErr = 1'b1;
    step();
    chk("R8 failStop", int'(failStop), 1);
    repeat (5) step();
    parityErr = 1'b0;
    chk("R8 stop sticky", int'(failStop), 1);
    chk("R8 hold sticky", int'(mainHold), 1);
    chk("R8 spare kept", int'(spareEnable), 1);
    chk("R8 no retry", int'(backoff), 0);

    // R7: calm windows clear the count
    doReset();
    wdReload = 8'd50;
    detectLimit = 4'd3;
    quietLimit = 8'd5;
    n = 0;
    for (int r = 0; r < 4; r++) begin
      parityErr = 1'b1;
      step();
      parityErr = 1'b0;
      if (goSpare) n++;
      repeat (12) step();
    end
    chk("R7 no switchover", n, 0);
    chk("R7 spare off", int'(spareEnable), 0);

    // R10: limit 0 acts as 1
    doReset();
    detectLimit = 4'd0;
    quietLimit = 8'd200;
    parityErr = 1'b1;
    step();
    parityErr = 1'b0;
    chk("R10 immediate switchover", int'(goSpare), 1);

    // R9: errors during a retry window are not counted
    doReset();
    detectLimit = 4'd2;
    parityErr = 1'b1;
    step();
    chk("R9 retry opened", int'(backoff), 1);
    step();
    step();
    parityErr = 1'b0;
    chk("R9 back to run", int'(backoff), 0);
    chk("R9 no switchover", int'(goSpare), 0);
    step();
    parityErr = 1'b1;
    step();
    parityErr = 1'b0;
    chk("R9 second counted detection switches", int'(goSpare), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule